// File: doc/BRIEF.md
# Dual-Timing-Mode Synchronous FIFO

This block is a single-clock first-in first-out buffer with one write side and one read side. Its timing mode is sampled while reset is held. In standard timing, a read edge pulls the head word into a registered output, and the two status outputs report "not empty" and "not full". In fall-through timing, the head word moves to the output register by itself. The read-side status then means "valid word on the output" and the write-side status means "room to write".

Each side accepts an access only on a rising edge where its active-low select is low and its active-high enable is high. The read select also drives an output-enable that models the tri-state output. A write to a full array or a read with nothing to deliver is dropped. Neither pointers nor data change.

Top module: `dual_mode_fifo`

## Requirements
- R1: The level on `mode_sel_i` is captured on every rising edge while `rst_n` is low: 1 selects standard timing and 0 selects fall-through timing. After reset is released, later changes of `mode_sel_i` have no effect until the next reset.
- R2: A write happens only on an edge where `wr_cs_n_i` is 0 and `wr_en_i` is 1. A read happens only on an edge where `rd_cs_n_i` is 0 and `rd_en_i` is 1. An edge without both conditions changes no stored word, pointer or output.
- R3: In standard timing, `rd_flag_o` is 1 exactly when the array holds at least one word (0 means empty). The word taken by a read edge is on `rd_data_o` right after that edge.
- R4: In fall-through timing, a word written into an empty buffer reaches `rd_data_o` at the second rising edge after its write edge, with no read, and `rd_flag_o` rises at that same edge. A read edge consumes the word on the output. If the array holds more words, the next word replaces it at that same edge.
- R5: `wr_flag_o` is 1 exactly when the storage array holds fewer than DEPTH words. In fall-through timing the output register holds one more word on top of those. A write while `wr_flag_o` is 0 is dropped.
- R6: A read with nothing to deliver is dropped: in standard timing `rd_data_o` keeps its value, and in either mode the next word written is the next word read.
- R7: `rd_oe_o` is 1 when `rd_cs_n_i` is 0 and 0 when it is 1.
- R8: Words leave in the order they were written, with their 36 bits unchanged.
- R9: After reset, `rd_flag_o` is 0, `wr_flag_o` is 1 and `rd_data_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state and flags change on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel_i | input | 1 | Timing mode level captured during reset (1 standard, 0 fall-through) |
| wr_cs_n_i | input | 1 | Write-side select, active low |
| wr_en_i | input | 1 | Write-side enable, active high |
| wr_data_i | input | DATA_W | Word to store |
| rd_cs_n_i | input | 1 | Read-side select, active low |
| rd_en_i | input | 1 | Read-side enable, active high |
| rd_data_o | output | DATA_W | Registered output word |
| rd_oe_o | output | 1 | Output enable, models the tri-state data output |
| rd_flag_o | output | 1 | Not-empty (standard) or output-ready (fall-through) |
| wr_flag_o | output | 1 | Not-full (standard) or input-ready (fall-through) |

## Verification
The hardest state to reach from the ports is the fall-through buffer at full capacity. In that state the array is full and the output register also holds a word, so the write-side flag must fall one word later than the array size alone suggests. The bench reaches it with DEPTH set to 8. It writes nine words back to back after a fall-through reset and then tries a tenth write. It then drains all nine words and checks their order and that the extra word never appears. The same run also toggles the mode pin after reset, which shows that the captured mode does not follow the pin.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  typedef enum logic {
    TM_FALLTHRU = 1'b0,
    TM_STANDARD = 1'b1
  } tmode_e;

  // next slot of a circular index
  function automatic int unsigned wrap_inc(input int unsigned idx, input int unsigned depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction

  // fill level after one edge
  function automatic int unsigned level_next(input int unsigned lvl, input logic push,
                                             input logic pop);
    if (push && !pop) return lvl + 1;
    if (pop && !push) return lvl - 1;
    return lvl;
  endfunction
endpackage

// File: rtl/dmf_ctrl.sv
module dmf_ctrl #(
  parameter int DEPTH = 1024,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] level
);
  import dmf_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= PTR_W'(wrap_inc(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PTR_W'(wrap_inc(int'(rd_ptr), DEPTH));
      level <= CNT_W'(level_next(int'(level), push, pop));
    end
  end

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(DEPTH));
  a_r5_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (level == CNT_W'(DEPTH) && !pop) |=> (level == CNT_W'(DEPTH)));
  a_r6_empty_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0 && !push) |=> $stable(rd_ptr));
endmodule

// File: rtl/dmf_store.sv
module dmf_store #(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 1024,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dmf_outstage.sv
module dmf_outstage #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dmf_pkg::tmode_e   mode,
  input  logic              rd_req,
  input  logic              have_words,
  input  logic [DATA_W-1:0] head_word,
  output logic              pop,
  output logic [DATA_W-1:0] dout,
  output logic              valid
);
  import dmf_pkg::*;

  logic take_out;

  always_comb begin
    if (mode == TM_STANDARD) begin
      pop      = rd_req && have_words;
      take_out = 1'b0;
    end else begin
      take_out = rd_req && valid;
      pop      = have_words && (!valid || take_out);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout  <= '0;
      valid <= 1'b0;
    end else begin
      if (pop) dout <= head_word;
      if (mode == TM_FALLTHRU) begin
        if (pop)           valid <= 1'b1;
        else if (take_out) valid <= 1'b0;
      end
    end
  end

  a_r4_fall_through_load: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TM_FALLTHRU && !valid && have_words) |=> valid);
  a_r6_std_empty_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TM_STANDARD && !have_words && rd_req) |=> $stable(dout));
  a_r4_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TM_FALLTHRU && valid && !rd_req) |=> (valid && $stable(dout)));
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 1024,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sel_i,
  input  logic              wr_cs_n_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_cs_n_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_oe_o,
  output logic              rd_flag_o,
  output logic              wr_flag_o
);
  import dmf_pkg::*;

  tmode_e            mode_q;
  logic              wr_req, rd_req, push, pop, have_words, out_valid;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  level;
  logic [DATA_W-1:0] head_word;

  // mode follows the pin only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= tmode_e'(mode_sel_i);
  end

  assign wr_req     = !wr_cs_n_i && wr_en_i;
  assign rd_req     = !rd_cs_n_i && rd_en_i;
  assign have_words = (level != '0);
  assign wr_flag_o  = (level != CNT_W'(DEPTH));
  assign push       = wr_req && wr_flag_o;
  assign rd_flag_o  = (mode_q == TM_STANDARD) ? have_words : out_valid;
  assign rd_oe_o    = !rd_cs_n_i;

  dmf_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .level(level)
  );

  dmf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
    .clk(clk), .we(push), .waddr(wr_ptr), .wdata(wr_data_i),
    .raddr(rd_ptr), .rdata(head_word)
  );

  dmf_outstage #(.DATA_W(DATA_W)) out_i (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .rd_req(rd_req),
    .have_words(have_words), .head_word(head_word), .pop(pop),
    .dout(rd_data_o), .valid(out_valid)
  );

  a_r1_mode_static: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(mode_q));
  a_r2_gated_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_req && !pop) |=> $stable(level));
  a_r5_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_flag_o && wr_req) |=> $stable(wr_ptr));
endmodule

// File: tb/dual_mode_fifo_tb_top.sv
module dual_mode_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 36;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n, mode_sel, wr_cs_n, wr_en, rd_cs_n, rd_en;
  logic [DW-1:0] wr_data, rd_data;
  logic rd_oe, rd_flag, wr_flag;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_mode_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel_i(mode_sel),
    .wr_cs_n_i(wr_cs_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_cs_n_i(rd_cs_n), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .rd_oe_o(rd_oe), .rd_flag_o(rd_flag), .wr_flag_o(wr_flag)
  );

  task automatic chk(input string req, input string what, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    wr_cs_n = 1'b1; wr_en = 1'b0; rd_cs_n = 1'b1; rd_en = 1'b0; wr_data = '0;
  endtask

  task automatic do_reset(input logic m);
    idle(); mode_sel = m; rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [DW-1:0] d);
    wr_cs_n = 1'b0; wr_en = 1'b1; wr_data = d; tick(); idle();
  endtask

  task automatic rd();
    rd_cs_n = 1'b0; rd_en = 1'b1; tick(); idle();
  endtask

  task automatic t_reset();
    do_reset(1'b1);
    chk("R9", "rd_flag", 36'(rd_flag), 36'd0);
    chk("R9", "wr_flag", 36'(wr_flag), 36'd1);
    chk("R9", "rd_data", rd_data, 36'd0);
  endtask

  task automatic t_std_basic();
    do_reset(1'b1);
    wr(36'hA_0000_0001);
    chk("R3", "rd_flag after write", 36'(rd_flag), 36'd1);
    wr(36'hA_0000_0002); wr(36'hA_0000_0003);
    chk("R3", "no data before read", rd_data, 36'd0);
    rd(); chk("R8", "word1", rd_data, 36'hA_0000_0001);
    rd(); chk("R8", "word2", rd_data, 36'hA_0000_0002);
    rd(); chk("R3", "word3", rd_data, 36'hA_0000_0003);
    chk("R3", "empty flag", 36'(rd_flag), 36'd0);
    rd(); chk("R6", "empty read keeps data", rd_data, 36'hA_0000_0003);
    chk("R6", "still empty", 36'(rd_flag), 36'd0);
    wr(36'hB_0000_0001); rd();
    chk("R6", "next word after empty read", rd_data, 36'hB_0000_0001);
  endtask

  task automatic t_gating();
    do_reset(1'b1);
    wr_cs_n = 1'b1; wr_en = 1'b1; wr_data = 36'h1; tick(); idle();
    chk("R2", "write with select high", 36'(rd_flag), 36'd0);
    wr_cs_n = 1'b0; wr_en = 1'b0; wr_data = 36'h2; tick(); idle();
    chk("R2", "write with enable low", 36'(rd_flag), 36'd0);
    wr(36'hC_0000_0001);
    rd_cs_n = 1'b1; rd_en = 1'b1; tick();
    chk("R7", "oe with select high", 36'(rd_oe), 36'd0);
    idle();
    chk("R2", "read with select high", rd_data, 36'd0);
    rd_cs_n = 1'b0; rd_en = 1'b0; tick();
    chk("R7", "oe with select low", 36'(rd_oe), 36'd1);
    idle();
    chk("R2", "read with enable low", rd_data, 36'd0);
    rd(); chk("R2", "gated read kept word", rd_data, 36'hC_0000_0001);
  endtask

  task automatic t_std_full();
    do_reset(1'b1);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R5", "room before full", 36'(wr_flag), 36'd1);
      wr(36'hD_0000_0000 + 36'(i));
    end
    chk("R5", "full", 36'(wr_flag), 36'd0);
    wr(36'hD_EAD0_0000);
    for (int i = 0; i < DEPTH; i++) begin
      rd(); chk("R5", "drain order", rd_data, 36'hD_0000_0000 + 36'(i));
    end
    chk("R5", "drop left empty", 36'(rd_flag), 36'd0);
  endtask

  task automatic t_fwft();
    do_reset(1'b0);
    mode_sel = 1'b1; // no effect after reset
    wr(36'hE_0000_0001);
    chk("R4", "not ready one edge after write", 36'(rd_flag), 36'd0);
    tick();
    chk("R4", "ready at second edge", 36'(rd_flag), 36'd1);
    chk("R1", "word fell through", rd_data, 36'hE_0000_0001);
    wr(36'hE_0000_0002); wr(36'hE_0000_0003);
    chk("R4", "head held without read", rd_data, 36'hE_0000_0001);
    rd(); chk("R4", "next loaded on read edge", rd_data, 36'hE_0000_0002);
    rd(); chk("R8", "third word", rd_data, 36'hE_0000_0003);
    rd(); chk("R4", "ready drops", 36'(rd_flag), 36'd0);
    rd(); chk("R6", "empty read ignored", 36'(rd_flag), 36'd0);
    wr(36'hF_0000_0001); tick();
    chk("R6", "next word after empty read", rd_data, 36'hF_0000_0001);
  endtask

  task automatic t_fwft_full();
    do_reset(1'b0);
    for (int i = 0; i <= DEPTH; i++) wr(36'h5_0000_0000 + 36'(i));
    chk("R5", "input-ready low at DEPTH+1", 36'(wr_flag), 36'd0);
    wr(36'h5_DEAD_0000);
    for (int i = 0; i <= DEPTH; i++) begin
      chk("R5", "fall-through drain", rd_data, 36'h5_0000_0000 + 36'(i));
      rd();
    end
    chk("R5", "drained", 36'(rd_flag), 36'd0);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_std_basic(); t_gating(); t_std_full(); t_fwft(); t_fwft_full();
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule